// File: doc/BRIEF.md
# PHY Tuning Bit-Serial Write Sequencer

This block writes the internal tuning bits of up to four USB PHYs through one shared 16-bit control word. A command names a PHY, an 8-bit start address, an 8-bit data word and a bit count. The sequencer sends the field one bit at a time, least significant bit first. For each bit it places an address and a data bit in the control word, then pulses the strobe bit that belongs to the chosen PHY. Each PHY latches the data bit into the addressed tuning cell when its strobe rises.

A mode input selects between two variants. The newer variant clears the whole control word once before the first bit. The older variant keeps the previous contents until the first bit is placed. The sequencer raises busy while it is working and pulses done when a command ends. Commands with an empty or oversized bit count complete at once. Commands that name a PHY that does not exist are refused with a one-cycle error pulse.

Top module: `tuneBitSequencer`

## Requirements
- R1: The control word carries the bit address in bits 15:8 and the data bit in bit 7. The strobe for PHY n is bit 2*n. Bits 1, 3 and 5 are always zero.
- R2: For bit i of a command (i counted from 0), the address field equals the start address plus i, modulo 256. The data bit equals bit i of the data word, so bits go out least significant first.
- R3: Each bit passes through three phases, each held for PHASE_CYC cycles: data placed with the strobe low, then the strobe high, then the strobe low. The address and data fields never change while a strobe is high. From acceptance to the end of the last phase, busy stays high for 1 + 3*PHASE_CYC*count cycles.
- R4: Each bit produces exactly one rising edge on the selected PHY's strobe bit. No other strobe bit ever rises, and no strobe is high while idle.
- R5: With newVariant = 1, the control word reads all zero in the first busy cycle. With newVariant = 0, the control word in that cycle is unchanged from before the command.
- R6: A start request while busy is ignored. The running command finishes with its own timing and data, and the PHY named in the ignored request is left untouched.
- R7: done is high for exactly one cycle, the cycle after the last low phase ends, with busy low.
- R8: A bit count of 0 or above 8 produces done in the next cycle, with no busy, no strobe and no change to the control word.
- R9: A PHY index above 3 produces errFlag for one cycle in the next cycle, with no done, no busy and no change to the control word.
- R10: During and after reset, the control word is zero and busy, done and errFlag are low.
- R11: The block carries out the usual tuning writes: 1 bit of value 1 at 0x0C on PHY 0 (calibration enable), 5 bits of 0x14 at 0x20 (transmit amplitude), 2 bits at 0x2A (disconnect threshold), and 2 bits at 0x3C (squelch: 0 enables it, 2 disables it).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newVariant | input | 1 | 1: clear the control word before the first bit |
| startReq | input | 1 | Command request, sampled only while idle |
| phyIdx | input | 3 | Target PHY index |
| startAddr | input | 8 | Address of the first bit |
| dataWord | input | 8 | Field value, sent LSB first |
| bitCount | input | 4 | Number of bits to send (1 to 8 are valid) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | One-cycle pulse when a PHY index is refused |
| ctrlWord | output | 16 | Shared PHY control word |

## Verification
A wrong internal state shows up at the shared control word within one phase. A stale shift register or address counter writes a wrong bit or a wrong address at the very next strobe rise. A wrong phase counter or bit counter changes the busy length or the number of strobe pulses seen before done. A bad PHY latch raises the wrong strobe bit, and a behavioural shadow receiver on the control word exposes that the moment the command completes. The bench compares every strobe rise against the address and bit it computes on its own, and after each command it compares all four shadow registers in full.

// File: rtl/tuneSeqPkg.sv
package tuneSeqPkg;

  localparam int CW_W     = 16;
  localparam int ADDR_LSB = 8;
  localparam int DATA_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } seqState_e;

  typedef struct packed {
    logic loadCmd;
    logic clearWord;
    logic placeFirst;
    logic placeNext;
    logic raiseStrobe;
    logic dropStrobe;
  } seqAct_t;

endpackage

// File: rtl/tuneSeqCtrl.sv
module tuneSeqCtrl
  import tuneSeqPkg::*;
#(
  parameter int NUM_PHY   = 4,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 8,
  parameter int PHASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             newVariant,
  input  logic [IDX_W-1:0] phyIdx,
  input  logic [CNT_W-1:0] bitCount,
  output seqAct_t          act,
  output logic             busy,
  output logic             done,
  output logic             errFlag
);

  localparam int PH_W = $clog2(PHASE_CYC) + 1;

  seqState_e        state, nextState;
  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic             phaseEnd;
  logic             badPhy, emptyCmd;
  logic             doneSet, errSet;
  logic             doneQ, errQ;

  assign phaseEnd = (phaseCnt == PH_W'(PHASE_CYC - 1));
  assign badPhy   = (int'(phyIdx) >= NUM_PHY);
  assign emptyCmd = (bitCount == '0) || (int'(bitCount) > DATA_W);

  always_comb begin
    nextState = state;
    act       = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (badPhy) begin
            errSet = 1'b1;
          end else if (emptyCmd) begin
            doneSet = 1'b1;
          end else begin
            act.loadCmd   = 1'b1;
            act.clearWord = newVariant;
            nextState     = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        act.placeFirst = 1'b1;
        nextState      = ST_SETUP;
      end
      ST_SETUP: begin
        if (phaseEnd) begin
          act.raiseStrobe = 1'b1;
          nextState       = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (phaseEnd) begin
          act.dropStrobe = 1'b1;
          nextState      = ST_LOW;
        end
      end
      ST_LOW: begin
        if (phaseEnd) begin
          if (bitsLeft == CNT_W'(1)) begin
            doneSet   = 1'b1;
            nextState = ST_IDLE;
          end else begin
            act.placeNext = 1'b1;
            nextState     = ST_SETUP;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitsLeft <= '0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state || state == ST_IDLE) begin
        phaseCnt <= '0;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
      if (act.loadCmd) begin
        bitsLeft <= bitCount;
      end else if (act.placeNext) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
      doneQ <= doneSet;
      errQ  <= errSet;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign errFlag = errQ;

endmodule

// File: rtl/tuneSeqDatapath.sv
module tuneSeqDatapath
  import tuneSeqPkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqAct_t           act,
  input  logic [IDX_W-1:0]  phyIdx,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataWord,
  output logic [CW_W-1:0]   ctrlWord
);

  localparam int PHY_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

  logic [PHY_W-1:0]  phyReg;
  logic [ADDR_W-1:0] addrReg, addrInc;
  logic [DATA_W-1:0] shiftReg;
  logic [CW_W-1:0]   wordQ;
  int                strobePos;

  assign addrInc   = addrReg + 1'b1;
  assign strobePos = 2 * int'(phyReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ    <= '0;
      phyReg   <= '0;
      addrReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (act.loadCmd) begin
        phyReg   <= phyIdx[PHY_W-1:0];
        addrReg  <= startAddr;
        shiftReg <= dataWord;
        if (act.clearWord) begin
          wordQ <= '0;
        end
      end
      if (act.placeFirst) begin
        wordQ[ADDR_LSB +: ADDR_W] <= addrReg;
        wordQ[DATA_BIT]           <= shiftReg[0];
        wordQ[strobePos]          <= 1'b0;
      end
      if (act.placeNext) begin
        addrReg                   <= addrInc;
        shiftReg                  <= shiftReg >> 1;
        wordQ[ADDR_LSB +: ADDR_W] <= addrInc;
        wordQ[DATA_BIT]           <= shiftReg[1];
      end
      if (act.raiseStrobe) begin
        wordQ[strobePos] <= 1'b1;
      end
      if (act.dropStrobe) begin
        wordQ[strobePos] <= 1'b0;
      end
    end
  end

  assign ctrlWord = wordQ;

endmodule

// File: rtl/tuneBitSequencer.sv
module tuneBitSequencer
  import tuneSeqPkg::*;
#(
  parameter int NUM_PHY   = 4,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int PHASE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newVariant,
  input  logic              startReq,
  input  logic [IDX_W-1:0]  phyIdx,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [CNT_W-1:0]  bitCount,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [15:0]       ctrlWord
);

  seqAct_t seqAct;

  tuneSeqCtrl #(
    .NUM_PHY  (NUM_PHY),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .PHASE_CYC(PHASE_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .newVariant(newVariant),
    .phyIdx    (phyIdx),
    .bitCount  (bitCount),
    .act       (seqAct),
    .busy      (busy),
    .done      (done),
    .errFlag   (errFlag)
  );

  tuneSeqDatapath #(
    .NUM_PHY(NUM_PHY),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .act      (seqAct),
    .phyIdx   (phyIdx),
    .startAddr(startAddr),
    .dataWord (dataWord),
    .ctrlWord (ctrlWord)
  );

endmodule

// File: rtl/tuneSeqChecker.sv
module tuneSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        errFlag,
  input logic [15:0] ctrlWord
);

  logic [3:0] strobes;
  logic       anyStrobe;

  assign strobes   = {ctrlWord[6], ctrlWord[4], ctrlWord[2], ctrlWord[0]};
  assign anyStrobe = |strobes;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)); // R4

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !anyStrobe); // R4

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[1] == 1'b0) && (ctrlWord[3] == 1'b0) && (ctrlWord[5] == 1'b0)); // R1

  AST_FIELDS_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe && !$past(anyStrobe) |-> $stable(ctrlWord[15:7])); // R3

  AST_ADDR_MOVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlWord[15:8]) |-> !anyStrobe); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !errFlag); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy && !done); // R9

endmodule

bind tuneBitSequencer tuneSeqChecker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .errFlag (errFlag),
  .ctrlWord(ctrlWord)
);

// File: tb/tuneShadowRx.sv
module tuneShadowRx #(
  parameter int NUM_PHY = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [15:0]              ctrlWord,
  output logic [NUM_PHY*256-1:0]   shadowFlat
);

  logic [15:0] prevWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWord   <= '0;
      shadowFlat <= '0;
    end else begin
      prevWord <= ctrlWord;
      for (int n = 0; n < NUM_PHY; n++) begin
        if (ctrlWord[2*n] && !prevWord[2*n]) begin
          shadowFlat[n*256 + int'(ctrlWord[15:8])] <= ctrlWord[7];
        end
      end
    end
  end

endmodule

// File: tb/tuneBitSequencer_tb_top.sv
module tuneBitSequencer_tb_top;

  localparam int PHASE = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        newVariant = 1'b0;
  logic        startReq = 1'b0;
  logic [2:0]  phyIdx = '0;
  logic [7:0]  startAddr = '0;
  logic [7:0]  dataWord = '0;
  logic [3:0]  bitCount = '0;
  logic        busy, done, errFlag;
  logic [15:0] ctrlWord;
  logic [1023:0] shadowFlat;
  logic [1023:0] expFlat = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tuneBitSequencer #(.PHASE_CYC(PHASE)) dut_i (
    .clk(clk), .rstN(rstN), .newVariant(newVariant), .startReq(startReq),
    .phyIdx(phyIdx), .startAddr(startAddr), .dataWord(dataWord),
    .bitCount(bitCount), .busy(busy), .done(done), .errFlag(errFlag),
    .ctrlWord(ctrlWord)
  );

  tuneShadowRx #(.NUM_PHY(4)) rx_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .shadowFlat(shadowFlat)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actV, input longint expV);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actV, expV);
    end
  endtask

  task automatic chkShadows(input string req);
    for (int n = 0; n < 4; n++) begin
      chk(shadowFlat[n*256 +: 256] == expFlat[n*256 +: 256], req,
          $sformatf("shadow of PHY %0d", n),
          longint'(shadowFlat[n*256 +: 64]), longint'(expFlat[n*256 +: 64]));
    end
  endtask

  task automatic pulseStart(input int phy, input int addr, input int data,
                            input int cnt, input bit mode);
    @(negedge clk);
    startReq   = 1'b1;
    phyIdx     = 3'(phy);
    startAddr  = 8'(addr);
    dataWord   = 8'(data);
    bitCount   = 4'(cnt);
    newVariant = mode;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic runCmd(input int phy, input int addr, input int data,
                        input int cnt, input bit mode, input bit inject,
                        input string req);
    logic [15:0] prevWord;
    logic [3:0]  stb, prevStb;
    int busyCnt, k, guard;
    prevWord = ctrlWord;
    pulseStart(phy, addr, data, cnt, mode);
    chk(busy == 1'b1, "R3", "busy after accept", busy, 1);
    if (mode) chk(ctrlWord == 16'h0, "R5", "cleared word in first cycle", ctrlWord, 0);
    else      chk(ctrlWord == prevWord, "R5", "kept word in first cycle", ctrlWord, prevWord);
    busyCnt = 1;
    k = 0;
    prevStb = 4'b0;
    guard = 0;
    while (guard < 1000) begin
      guard++;
      if (inject && busyCnt == 5) begin
        startReq  = 1'b1;
        phyIdx    = 3'((phy + 1) % 4);
        startAddr = 8'h77;
        dataWord  = 8'hFF;
        bitCount  = 4'd8;
      end
      @(negedge clk);
      startReq = 1'b0;
      if (!busy) break;
      busyCnt++;
      stb = {ctrlWord[6], ctrlWord[4], ctrlWord[2], ctrlWord[0]};
      if (stb != 4'b0 && prevStb == 4'b0) begin
        chk(stb == 4'(1 << phy), "R4", "strobe bit of selected PHY", stb, 1 << phy);
        chk(ctrlWord[15:8] == 8'(addr + k), "R2", "address at strobe rise",
            ctrlWord[15:8], (addr + k) & 255);
        chk(ctrlWord[7] == 1'((data >> k) & 1), "R2", "data bit at strobe rise",
            ctrlWord[7], (data >> k) & 1);
        k++;
      end
      prevStb = stb;
    end
    chk(done == 1'b1, "R7", "done after last low phase", done, 1);
    chk(busyCnt == 1 + 3 * PHASE * cnt, "R3", "busy length", busyCnt, 1 + 3 * PHASE * cnt);
    chk(k == cnt, "R4", "strobe pulse count", k, cnt);
    for (int i = 0; i < cnt; i++) begin
      expFlat[phy*256 + ((addr + i) & 255)] = 1'((data >> i) & 1);
    end
    chkShadows(req);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done lasts one cycle", done, 0);
  endtask

  task automatic rejectCmd(input int phy, input int cnt, input bit isErr,
                           input string req);
    logic [15:0] prevWord;
    prevWord = ctrlWord;
    pulseStart(phy, 8'h55, 8'hFF, cnt, 1'b1);
    chk(busy == 1'b0, req, "no busy on refused command", busy, 0);
    if (isErr) begin
      chk(errFlag == 1'b1 && done == 1'b0, req, "error pulse only", {errFlag, done}, 2'b10);
    end else begin
      chk(done == 1'b1 && errFlag == 1'b0, req, "immediate done", {errFlag, done}, 2'b01);
    end
    chk(ctrlWord == prevWord, req, "control word unchanged", ctrlWord, prevWord);
    @(negedge clk);
    chk(done == 1'b0 && errFlag == 1'b0, req, "pulse is one cycle", {errFlag, done}, 0);
    chkShadows(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrlWord == 16'h0 && !busy && !done && !errFlag, "R10", "state in reset",
        {ctrlWord, busy, done, errFlag}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctrlWord == 16'h0 && !busy && !done && !errFlag, "R10", "state after reset",
        {ctrlWord, busy, done, errFlag}, 0);

    // R11: usual tuning writes
    runCmd(0, 8'h0C, 1, 1, 1'b0, 1'b0, "R11");
    runCmd(1, 8'h20, 8'h14, 5, 1'b1, 1'b0, "R11");
    runCmd(2, 8'h2A, 3, 2, 1'b0, 1'b0, "R11");
    runCmd(3, 8'h3C, 2, 2, 1'b1, 1'b0, "R11");
    runCmd(3, 8'h3C, 0, 2, 1'b0, 1'b0, "R11");

    // R2: address wraps past 0xFF
    runCmd(1, 8'hFE, 8'hA5, 4, 1'b0, 1'b0, "R2");

    // R6: start during busy is ignored
    runCmd(2, 8'h40, 8'h5A, 3, 1'b1, 1'b1, "R6");

    // R8 / R9: refused and empty commands
    rejectCmd(0, 0, 1'b0, "R8");
    rejectCmd(1, 9, 1'b0, "R8");
    rejectCmd(2, 15, 1'b0, "R8");
    rejectCmd(4, 3, 1'b1, "R9");
    rejectCmd(7, 8, 1'b1, "R9");

    // R1 R2 R3 R4 R5: sweep over PHY, count and variant
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 1; c <= 8; c++) begin
          runCmd(p, (c * 31 + p * 17 + m * 100) & 255,
                 (p * 53 + c * 29 + m * 7) & 255, c, 1'(m), 1'b0, "R2");
        end
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule